// File: doc/BRIEF.md
# Radix Address Qualification Front-End

This block is the first stage of a radix-tree address translation path. It accepts one memory access request at a time. Each request carries a 64-bit effective address, an access type (load, store or instruction fetch), the translation-control machine-state bits and the partition and process ID registers. For each request it decides whether the access runs untranslated (real mode) or translated (virtual mode).

In real mode the block forms the physical address at once. It clears the top address nibble and, when the hypervisor bit calls for it, merges in a hypervisor offset register. In virtual mode it reads the address quadrant and produces the partition ID and process ID that a following table walker uses. It also passes the effective address on with the quadrant bits stripped. Quadrants that a guest may not use give a segment fault instead. A data segment fault also loads the faulting address into a held fault-address output.

The block is one registered stage. A request is accepted on a `req_valid`/`req_ready` handshake. Exactly one of the response pulse or the fault pulse follows on the next cycle. No new request is taken while that pulse is showing.

Top module: `radix_qual_frontend`

## Requirements
- R1: After a synchronous active-low reset, `rsp_valid` and `flt_valid` are 0, `req_ready` is 1, `flt_kind` is 0 and `flt_dar` is 0.
- R2: `acc` encodes 0 = load, 1 = store, 2 = instruction fetch, and 3 is handled as a load. A fetch is real mode when `msr_ir` is 0. Any other access is real mode when `msr_dr` is 0. `rsp_real` reports the choice.
- R3: In real mode, `rsp_raddr` equals `req_ea` with bits 63:60 cleared, when no hypervisor offset applies. `rsp_lpid` and `rsp_pid` are 0.
- R4: In real mode with `msr_hv` = 1 and `req_ea[63]` = 0, `rsp_raddr` is the masked address ORed with `hrmor`. With `req_ea[63]` = 1, or with `msr_hv` = 0, `hrmor` has no effect.
- R5: In virtual mode with quadrant `req_ea[63:62]` = 0, the response carries `rsp_lpid` = `lpid_reg` and `rsp_pid` = `pid_reg`.
- R6: In virtual mode with quadrant 3, the response carries `rsp_lpid` = `lpid_reg` and `rsp_pid` = 0.
- R7: In virtual mode, quadrants 1 and 2 raise `flt_valid` instead of `rsp_valid`. `flt_kind` is 2 (instruction segment) for a fetch and 1 (data segment) for any other access. It is 0 when no fault is reported.
- R8: A data segment fault loads `req_ea` into `flt_dar`. An instruction segment fault and any non-faulting access leave `flt_dar` unchanged.
- R9: A request is accepted when `req_valid` and `req_ready` are both 1. On the next cycle exactly one of `rsp_valid` or `flt_valid` is 1, for that cycle only. `req_ready` is 0 while either is 1, so a request held there is not taken.
- R10: On a virtual-mode response, `rsp_raddr` equals `req_ea` with bits 63:62 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Stage can accept a request |
| req_ea | input | 64 | Effective address |
| req_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| msr_ir | input | 1 | Instruction relocation enabled |
| msr_dr | input | 1 | Data relocation enabled |
| msr_hv | input | 1 | Hypervisor state |
| lpid_reg | input | 12 | Partition ID register |
| pid_reg | input | 20 | Process ID register |
| hrmor | input | 64 | Hypervisor real-mode offset |
| rsp_valid | output | 1 | Response pulse |
| rsp_real | output | 1 | Response was real mode |
| rsp_raddr | output | 64 | Real address, or stripped effective address |
| rsp_lpid | output | 12 | Qualified partition ID |
| rsp_pid | output | 20 | Qualified process ID |
| flt_valid | output | 1 | Segment fault pulse |
| flt_kind | output | 2 | 1 data segment, 2 instruction segment |
| flt_dar | output | 64 | Fault address of the last data segment fault |

## Verification
The assertions assume that the request inputs stay steady from the handshake edge until the following edge, and that `hrmor` and the ID registers do not change during a transaction. They also look one cycle back at the accepted address. The bench drives every input on the falling edge and drops `req_valid` right after acceptance, except in one deliberate hold test. It sweeps all access types, all relocate and hypervisor bit combinations and all four quadrants against a fixed `hrmor` with its high bits set, so the merge order of mask and offset is visible.

// File: rtl/radix_qual_pkg.sv
// Shared encodings for the radix address qualification front-end.
// Assumes access type and fault kind each fit in two bits.
package radix_qual_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_t;

    typedef enum logic [1:0] {
        FK_NONE = 2'd0,
        FK_DSEG = 2'd1,
        FK_ISEG = 2'd2
    } fkind_t;
endpackage

// File: rtl/ra_mode_sel.sv
// Chooses real or virtual mode for one access and forms the real-mode
// physical address. Purely combinational.
// Assumes: the fetch encoding comes from radix_qual_pkg; every other
// code is treated as a data access.
module ra_mode_sel
    import radix_qual_pkg::*;
#(
    parameter int EA_W   = 64,
    parameter int RM_CLR = 4
) (
    input  logic [EA_W-1:0] ea,
    input  logic [1:0]      acc,
    input  logic            ir,
    input  logic            dr,
    input  logic            hv,
    input  logic [EA_W-1:0] hrmor,
    output logic            real_mode,
    output logic [EA_W-1:0] real_addr
);
    localparam logic [EA_W-1:0] RM_MASK = {{RM_CLR{1'b0}}, {(EA_W-RM_CLR){1'b1}}};

    logic is_fetch;
    logic hv_off;

    // Mode choice and real address formation.
    always_comb begin
        is_fetch  = (acc == ACC_FETCH);
        real_mode = is_fetch ? !ir : !dr;
        hv_off    = hv && !ea[EA_W-1];
        real_addr = (ea & RM_MASK) | (hv_off ? hrmor : '0);
    end
endmodule

// File: rtl/ra_quad_dec.sv
// Decodes the effective-address quadrant into partition and process IDs.
// Reports quadrants a guest may not use as illegal. Purely combinational.
// Assumes the two top address bits hold the quadrant.
module ra_quad_dec #(
    parameter int EA_W   = 64,
    parameter int LPID_W = 12,
    parameter int PID_W  = 20
) (
    input  logic [EA_W-1:0]   ea,
    input  logic [LPID_W-1:0] lpid_reg,
    input  logic [PID_W-1:0]  pid_reg,
    output logic              legal,
    output logic [LPID_W-1:0] lpid,
    output logic [PID_W-1:0]  pid,
    output logic [EA_W-1:0]   virt_addr
);
    localparam int Q_W = 2;
    localparam logic [EA_W-1:0] V_MASK = {{Q_W{1'b0}}, {(EA_W-Q_W){1'b1}}};

    logic [Q_W-1:0] quad;

    // Quadrant to ID mapping.
    always_comb begin
        quad      = ea[EA_W-1 -: Q_W];
        virt_addr = ea & V_MASK;
        legal     = 1'b0;
        lpid      = '0;
        pid       = '0;
        case (quad)
            2'd0: begin
                legal = 1'b1;
                lpid  = lpid_reg;
                pid   = pid_reg;
            end
            2'd3: begin
                legal = 1'b1;
                lpid  = lpid_reg;
            end
            default: legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/ra_resp_stage.sv
// Single registered stage: accepts a request on the handshake and emits
// exactly one response or fault pulse on the next cycle. Also holds the
// data fault address.
// Assumes request inputs stay steady from the handshake edge on.
module ra_resp_stage
    import radix_qual_pkg::*;
#(
    parameter int EA_W   = 64,
    parameter int LPID_W = 12,
    parameter int PID_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [EA_W-1:0]   ea,
    input  logic [1:0]        acc,
    input  logic              real_mode,
    input  logic [EA_W-1:0]   real_addr,
    input  logic              legal,
    input  logic [LPID_W-1:0] q_lpid,
    input  logic [PID_W-1:0]  q_pid,
    input  logic [EA_W-1:0]   virt_addr,
    output logic              rsp_valid,
    output logic              rsp_real,
    output logic [EA_W-1:0]   rsp_raddr,
    output logic [LPID_W-1:0] rsp_lpid,
    output logic [PID_W-1:0]  rsp_pid,
    output logic              flt_valid,
    output logic [1:0]        flt_kind,
    output logic [EA_W-1:0]   flt_dar
);
    logic accept;
    logic seg_fault;
    logic is_fetch;

    // Handshake and outcome decode.
    always_comb begin
        req_ready = !(rsp_valid || flt_valid);
        accept    = req_valid && req_ready;
        seg_fault = !real_mode && !legal;
        is_fetch  = (acc == ACC_FETCH);
    end

    // Output register: pulses, payload and held fault address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            flt_valid <= 1'b0;
            rsp_real  <= 1'b0;
            rsp_raddr <= '0;
            rsp_lpid  <= '0;
            rsp_pid   <= '0;
            flt_kind  <= FK_NONE;
            flt_dar   <= '0;
        end else begin
            rsp_valid <= accept && !seg_fault;
            flt_valid <= accept && seg_fault;
            if (accept) begin
                rsp_real  <= real_mode;
                rsp_raddr <= real_mode ? real_addr : virt_addr;
                rsp_lpid  <= real_mode ? '0 : q_lpid;
                rsp_pid   <= real_mode ? '0 : q_pid;
                flt_kind  <= !seg_fault ? FK_NONE : (is_fetch ? FK_ISEG : FK_DSEG);
                if (seg_fault && !is_fetch) begin
                    flt_dar <= ea;
                end
            end
        end
    end

    // R9: never both pulses at once
    assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && flt_valid));

    // R9: an accepted request yields an outcome on the next cycle
    assert_accept_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid || flt_valid));

    // R9: outcome pulses last one cycle
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || flt_valid) |=> !(rsp_valid || flt_valid));

    // R7: a fault pulse always names a fault kind
    assert_fault_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> (flt_kind != FK_NONE));

    // R8: a data segment fault captures the accepted address
    assert_dar_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && flt_kind == FK_DSEG) |-> (flt_dar == $past(ea)));

    // R10: virtual responses have the quadrant bits stripped
    assert_virt_strip_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_real) |-> (rsp_raddr[EA_W-1 -: 2] == 2'b00));

    // R6: quadrant 3 gives process ID zero
    assert_q3_pid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_real && $past(ea[EA_W-1 -: 2]) == 2'b11) |-> (rsp_pid == '0));
endmodule

// File: rtl/radix_qual_frontend.sv
// Top of the radix address qualification front-end. It joins mode
// selection, quadrant decode and the registered response stage.
// Assumes hypervisor-mode quadrant rules and nested translation live elsewhere.
module radix_qual_frontend #(
    parameter int EA_W   = 64,
    parameter int LPID_W = 12,
    parameter int PID_W  = 20,
    parameter int RM_CLR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [EA_W-1:0]   req_ea,
    input  logic [1:0]        req_acc,
    input  logic              msr_ir,
    input  logic              msr_dr,
    input  logic              msr_hv,
    input  logic [LPID_W-1:0] lpid_reg,
    input  logic [PID_W-1:0]  pid_reg,
    input  logic [EA_W-1:0]   hrmor,
    output logic              rsp_valid,
    output logic              rsp_real,
    output logic [EA_W-1:0]   rsp_raddr,
    output logic [LPID_W-1:0] rsp_lpid,
    output logic [PID_W-1:0]  rsp_pid,
    output logic              flt_valid,
    output logic [1:0]        flt_kind,
    output logic [EA_W-1:0]   flt_dar
);
    logic              real_mode;
    logic [EA_W-1:0]   real_addr;
    logic              legal;
    logic [LPID_W-1:0] q_lpid;
    logic [PID_W-1:0]  q_pid;
    logic [EA_W-1:0]   virt_addr;

    ra_mode_sel #(.EA_W(EA_W), .RM_CLR(RM_CLR)) u_mode (
        .ea(req_ea), .acc(req_acc), .ir(msr_ir), .dr(msr_dr), .hv(msr_hv),
        .hrmor(hrmor), .real_mode(real_mode), .real_addr(real_addr)
    );

    ra_quad_dec #(.EA_W(EA_W), .LPID_W(LPID_W), .PID_W(PID_W)) u_quad (
        .ea(req_ea), .lpid_reg(lpid_reg), .pid_reg(pid_reg),
        .legal(legal), .lpid(q_lpid), .pid(q_pid), .virt_addr(virt_addr)
    );

    ra_resp_stage #(.EA_W(EA_W), .LPID_W(LPID_W), .PID_W(PID_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .ea(req_ea), .acc(req_acc), .real_mode(real_mode), .real_addr(real_addr),
        .legal(legal), .q_lpid(q_lpid), .q_pid(q_pid), .virt_addr(virt_addr),
        .rsp_valid(rsp_valid), .rsp_real(rsp_real), .rsp_raddr(rsp_raddr),
        .rsp_lpid(rsp_lpid), .rsp_pid(rsp_pid), .flt_valid(flt_valid),
        .flt_kind(flt_kind), .flt_dar(flt_dar)
    );
endmodule

// File: tb/radix_qual_frontend_test.sv
// Sweep bench for the radix address qualification front-end.
module radix_qual_frontend_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_ea = '0;
    logic [1:0]  req_acc = '0;
    logic        msr_ir = 1'b0, msr_dr = 1'b0, msr_hv = 1'b0;
    logic [11:0] lpid_reg = 12'hA5C;
    logic [19:0] pid_reg = 20'h3_1F2E;
    logic [63:0] hrmor = 64'hF300_0000_0470_0000;
    logic        rsp_valid, rsp_real, flt_valid;
    logic [63:0] rsp_raddr, flt_dar;
    logic [11:0] rsp_lpid;
    logic [19:0] rsp_pid;
    logic [1:0]  flt_kind;

    int checks = 0;
    int errors = 0;
    logic [63:0] dar_model = '0;

    always #10 clk = ~clk;

    radix_qual_frontend uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_ea(req_ea), .req_acc(req_acc), .msr_ir(msr_ir), .msr_dr(msr_dr),
        .msr_hv(msr_hv), .lpid_reg(lpid_reg), .pid_reg(pid_reg), .hrmor(hrmor),
        .rsp_valid(rsp_valid), .rsp_real(rsp_real), .rsp_raddr(rsp_raddr),
        .rsp_lpid(rsp_lpid), .rsp_pid(rsp_pid), .flt_valid(flt_valid),
        .flt_kind(flt_kind), .flt_dar(flt_dar)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One transaction with expected values computed from the requirements.
    task automatic run_one(input logic [63:0] ea, input logic [1:0] acc,
                           input logic ir, input logic dr, input logic hv);
        logic        fetch, realm, fault;
        logic [63:0] exp_addr;
        logic [1:0]  q;
        fetch = (acc == 2'd2);
        realm = fetch ? !ir : !dr;
        q     = ea[63:62];
        fault = !realm && (q == 2'd1 || q == 2'd2);
        if (realm) begin
            exp_addr = ea & 64'h0FFF_FFFF_FFFF_FFFF;
            if (hv && !ea[63]) exp_addr = exp_addr | hrmor;
        end else begin
            exp_addr = ea & 64'h3FFF_FFFF_FFFF_FFFF;
        end
        @(negedge clk);
        req_ea = ea; req_acc = acc; msr_ir = ir; msr_dr = dr; msr_hv = hv;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 outcome", {62'd0, rsp_valid, flt_valid}, {62'd0, !fault, fault});
        chk("R9 ready low", {63'd0, req_ready}, 64'd0);
        if (fault) begin
            chk("R7 kind", {62'd0, flt_kind}, fetch ? 64'd2 : 64'd1);
            if (!fetch) dar_model = ea;
        end else begin
            chk("R2 mode", {63'd0, rsp_real}, {63'd0, realm});
            if (realm) begin
                chk((hv && !ea[63]) ? "R4 offset" : "R3 mask", rsp_raddr, exp_addr);
                chk("R3 ids", {32'd0, rsp_lpid, rsp_pid}, 64'd0);
            end else begin
                chk("R10 vaddr", rsp_raddr, exp_addr);
                if (q == 2'd0)
                    chk("R5 ids", {32'd0, rsp_lpid, rsp_pid}, {32'd0, lpid_reg, pid_reg});
                else
                    chk("R6 ids", {32'd0, rsp_lpid, rsp_pid}, {32'd0, lpid_reg, 20'd0});
            end
        end
        chk("R8 dar", flt_dar, dar_model);
        @(posedge clk);
        @(negedge clk);
        chk("R9 pulse end", {62'd0, rsp_valid, flt_valid}, 64'd0);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 pulses", {62'd0, rsp_valid, flt_valid}, 64'd0);
        chk("R1 ready", {63'd0, req_ready}, 64'd1);
        chk("R1 kind", {62'd0, flt_kind}, 64'd0);
        chk("R1 dar", flt_dar, 64'd0);

        // Sweep of access type, relocate/hypervisor bits and quadrant.
        for (int a = 0; a < 4; a++)
            for (int m = 0; m < 8; m++)
                for (int q = 0; q < 4; q++) begin
                    logic [63:0] ea;
                    ea = 64'h3A5C_9617_0B2D_E48F ^ (64'(a * 37 + m * 11 + q) << 7)
                         ^ {2'b00, 2'(m + q), 60'd0};
                    ea[63:62] = 2'(q);
                    run_one(ea, 2'(a), m[0], m[1], m[2]);
                end

        // R9: a request held through the pulse cycle is taken only once ready returns.
        @(negedge clk);
        req_ea = 64'h0000_1234_5678_9ABC; req_acc = 2'd0;
        msr_ir = 1'b1; msr_dr = 1'b1; msr_hv = 1'b0;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R9 held first", {63'd0, rsp_valid}, 64'd1);
        @(posedge clk);
        @(negedge clk);
        chk("R9 held blocked", {62'd0, rsp_valid, flt_valid}, 64'd0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 held retaken", {63'd0, rsp_valid}, 64'd1);
        @(posedge clk);
        @(negedge clk);

        // R8: fetch fault after a data fault keeps the stored address.
        run_one(64'h4000_0000_0000_0100, 2'd1, 1'b1, 1'b1, 1'b0);
        run_one(64'h8000_0000_0000_0200, 2'd2, 1'b1, 1'b1, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule